// File: doc/BRIEF.md
# Infrared Carrier Pin Generator

This block drives one output pin that either carries an infrared remote-control carrier, sits at a fixed high idle level, or passes through an ordinary general-purpose output latch. A free-running tick counter, advanced only when the clock enable `tick_en` is high, sets the shape of the carrier. The period value gives the carrier length in ticks. The duty value gives how many ticks at the start of each period the carrier is high.

Two enable bits pick the pin mode. `ir_sel` hands the pin to the infrared function. `car_on` then chooses between the carrier and the idle-high level. Software forms bursts by toggling `car_on`. Dropping it returns the counter to zero, so each burst starts at the beginning of a carrier period. New period and duty values are held in shadow registers and take effect only at a period boundary, so a change never shortens or stretches the carrier period in progress.

Top module: `ir_carrier_gen`

## Requirements
- R1: When `ir_sel`=1 and `car_on`=1, `pin` shows the carrier waveform.
- R2: When `ir_sel`=1 and `car_on`=0, `pin` is 1.
- R3: When `ir_sel`=0, `pin` equals `gpio_q` whatever the value of `car_on`.
- R4: The carrier is high while the tick count is below the active duty value and low otherwise. The count advances by one on each clock with `tick_en`=1. It wraps to 0 after reaching active period minus 1. A period of 0 or 1 holds the count at 0. Clocks with `tick_en`=0 leave the count unchanged.
- R5: Period and duty values are sampled into the active registers on the clock at which the count wraps to 0. They are also sampled on every clock while the carrier is not running. Changes in the middle of a period do not affect that period.
- R6: With the carrier running, an active duty of 0 gives a constant low `pin`. An active duty greater than or equal to the active period gives a constant high `pin`.
- R7: While `ir_sel` and `car_on` are not both 1, the count is held at 0. A new burst therefore begins with the high phase at count 0.
- R8: After reset the count and the active period and duty registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Clock enable for the carrier counter |
| ir_sel | input | 1 | Hands the pin to the infrared function |
| car_on | input | 1 | Selects the carrier, otherwise idle high, when `ir_sel`=1 |
| period_val | input | CW | Carrier period in ticks |
| duty_val | input | CW | Carrier high time in ticks |
| gpio_q | input | 1 | General-purpose output latch value |
| pin | output | 1 | Pin drive value |

## Verification
The carrier is checked against a cycle-indexed expectation for several period and duty pairs. With `tick_en` held high, this shows the high/low split and the wrap point. With `tick_en` high on every other clock, a counter that ignored the enable becomes visible. A reload in the middle of a period checks that the old shape finishes before the new one starts. A burst stopped part-way and restarted tells a counter that resumes apart from one that restarts at 0. Duty 0, duty equal to the period and duty above the period cover the constant-level corners. Toggling `gpio_q` in both enable states separates the pass-through mode from the forced-high idle mode.

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          ir_sel,
  input  logic          car_on,
  input  logic [CW-1:0] period_val,
  input  logic [CW-1:0] duty_val,
  input  logic          gpio_q,
  output logic          pin
);

  logic [CW-1:0] cnt, per_q, duty_q;
  logic          run, wrap, wave;

  assign run  = ir_sel & car_on;
  assign wrap = ({1'b0, cnt} + 1'b1) >= {1'b0, per_q};
  assign wave = cnt < duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (!run) begin
      cnt    <= '0;
      per_q  <= period_val;
      duty_q <= duty_val;
    end else if (tick_en) begin
      if (wrap) begin
        cnt    <= '0;
        per_q  <= period_val;
        duty_q <= duty_val;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pin = ir_sel ? (car_on ? wave : 1'b1) : gpio_q;

endmodule

module ir_carrier_gen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          ir_sel,
  input logic          car_on,
  input logic          gpio_q,
  input logic          pin,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_q,
  input logic [CW-1:0] duty_q
);

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_sel && !car_on) |-> pin);

  a_r3_gpio_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_sel |-> (pin == gpio_q));

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_sel && car_on && per_q > 1) |-> (cnt < per_q));

  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_sel && car_on && !tick_en) |=> $stable(cnt));

  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_sel && car_on && !tick_en) |=> ($stable(per_q) && $stable(duty_q)));

  a_r6_duty_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_sel && car_on && duty_q == '0) |-> !pin);

  a_r7_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(ir_sel && car_on) |=> (cnt == '0));

endmodule

bind ir_carrier_gen ir_carrier_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ir_sel(ir_sel),
  .car_on(car_on), .gpio_q(gpio_q), .pin(pin), .cnt(cnt),
  .per_q(per_q), .duty_q(duty_q)
);

// File: tb/tb_ir_carrier_gen.sv
module tb_ir_carrier_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0, tick_en = 0, ir_sel = 0, car_on = 0, gpio_q = 0;
  logic [CW-1:0] period_val = 0, duty_val = 0;
  logic pin;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_carrier_gen #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ir_sel(ir_sel),
    .car_on(car_on), .period_val(period_val), .duty_val(duty_val),
    .gpio_q(gpio_q), .pin(pin)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (pin !== exp) begin
      errors++;
      $display("FAIL %s: pin=%b expected=%b at %0t", req, pin, exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    car_on = 0; ir_sel = 1; tick_en = 1;
    #1;
  endtask

  task automatic run_shape(input int p, input int d, input int n, input string req);
    idle();
    period_val = CW'(p); duty_val = CW'(d);
    next_cycle();
    car_on = 1;
    #1;
    for (int k = 0; k < n; k++) begin
      int ph;
      ph = (p < 2) ? 0 : k % p;
      check(req, ph < d);
      next_cycle();
    end
  endtask

  task automatic t_reset();
    ir_sel = 0; gpio_q = 1; #1;
    check("R8 reset gpio", 1'b1);
    ir_sel = 1; car_on = 0; #1;
    check("R8 reset idle", 1'b1);
    ir_sel = 0; gpio_q = 0;
    @(negedge clk); rst_n = 1;
    ir_sel = 1; car_on = 1; #1;
    check("R8 zero duty after reset", 1'b0);
    car_on = 0; ir_sel = 0;
  endtask

  task automatic t_gpio();
    @(negedge clk);
    ir_sel = 0; car_on = 1; tick_en = 1; period_val = 4; duty_val = 2;
    for (int k = 0; k < 6; k++) begin
      gpio_q = k[0]; #1;
      check("R3 gpio passthrough", k[0]);
      next_cycle();
    end
    ir_sel = 1; car_on = 0;
    for (int k = 0; k < 4; k++) begin
      gpio_q = k[0]; #1;
      check("R2 idle high", 1'b1);
      next_cycle();
    end
  endtask

  task automatic t_slow_tick();
    idle();
    period_val = 3; duty_val = 1;
    next_cycle();
    car_on = 1; tick_en = 0; #1;
    for (int k = 0; k < 12; k++) begin
      check("R4 tick enable gating", ((k / 2) % 3) < 1);
      @(negedge clk);
      tick_en = (k % 2 == 0);
      #1;
    end
    tick_en = 1;
  endtask

  task automatic t_reload();
    idle();
    period_val = 4; duty_val = 2;
    next_cycle();
    car_on = 1; #1;
    for (int k = 0; k < 16; k++) begin
      logic e;
      e = (k < 4) ? (k < 2) : (((k - 4) % 6) < 3);
      check("R5 reload at boundary", e);
      if (k == 1) begin period_val = 6; duty_val = 3; end
      next_cycle();
    end
  endtask

  task automatic t_restart();
    idle();
    period_val = 5; duty_val = 2;
    next_cycle();
    car_on = 1; #1;
    for (int k = 0; k < 3; k++) begin
      check("R1 burst", (k % 5) < 2);
      next_cycle();
    end
    car_on = 0; #1;
    check("R2 idle between bursts", 1'b1);
    next_cycle();
    car_on = 1; #1;
    for (int k = 0; k < 6; k++) begin
      check("R7 restart at count 0", (k % 5) < 2);
      next_cycle();
    end
  endtask

  initial begin
    t_reset();
    t_gpio();
    run_shape(4, 1, 12, "R1 carrier p4 d1");
    run_shape(7, 3, 14, "R4 carrier p7 d3");
    run_shape(1, 1, 4, "R4 period one");
    run_shape(6, 0, 8, "R6 duty zero");
    run_shape(5, 5, 8, "R6 duty equal period");
    run_shape(5, 9, 8, "R6 duty above period");
    t_slow_tick();
    t_reload();
    t_restart();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule